// File: doc/BRIEF.md
# Delay-Locked Loop Delay Controller

This block is the digital half of a delay-locked loop. It tunes a chain of identical delay cells so that the chain spans one reference clock period. Each cycle it reads a single early/late bit from an external phase detector and moves a delay setting code one step toward lock. The same period calibration is then used to shift a data strobe. A two-bit phase select picks how many calibrated cells the strobe passes through.

A two-bit frequency mode selects the operating band. Mode 0 (about 100–175 MHz) locks 12 cells and uses a 6-bit code. Mode 1 (150–230 MHz) locks 16 cells. Mode 2 (200–310 MHz) locks 12 cells. Mode 3 (240–400 MHz) locks 10 cells. Modes 1 to 3 use a 5-bit code. The strobe shift is (phase select + 1) cells, which gives these steps:

- modes 0 and 2: 30°
- mode 1: 22.5°
- mode 3: 36°

Reset may come from fabric logic or from a pin. A lock flag tells downstream capture logic when the loop has had its 256-cycle settling time since the last reset.

Top module: `dll_delay_ctrl`

## Requirements
- R1: While reset is applied, `delay_code` holds its midpoint and `locked` is 0. The midpoint is 32 in mode 0 and 16 in modes 1 to 3.
- R2: Reset is the OR of `fabric_rst` and `pin_rst`. Either input alone resets the block. Assertion acts at once. Release passes through a two-stage synchroniser, so the code keeps its midpoint through the second rising edge after release and first moves on the third.
- R3: Out of reset, each rising edge moves `delay_code` by exactly one step. It goes up when `pd_short` is 1 (chain shorter than one period) and down when `pd_short` is 0.
- R4: In mode 0, `delay_code` saturates at 63 and holds there while `pd_short` stays 1.
- R5: In modes 1, 2 and 3, bit 5 of `delay_code` is always 0 and the code saturates at 31.
- R6: `delay_code` saturates at 0 and holds there while `pd_short` stays 0.
- R7: `locked` stays 0 until 256 rising edges have passed with the internal reset released. It becomes 1 after the 258th rising edge following reset release and stays 1 until the next reset or mode change.
- R8: `shift_taps` equals `phase_sel` + 1, so it lies in 1 to 4, in every mode and at all times.
- R9: A reset while locked drops `locked` at once, returns the code to its midpoint and restarts the full 256-cycle wait.
- R10: A change of `freq_mode` outside reset acts as a reset. On that edge the code loads the new mode's midpoint, `locked` drops, and the 256-cycle wait restarts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock |
| fabric_rst | input | 1 | Reset from fabric logic, active high, asynchronous assert |
| pin_rst | input | 1 | Reset from an input pin, active high, asynchronous assert |
| freq_mode | input | 2 | Operating band, 0 to 3 |
| phase_sel | input | 2 | Strobe shift choice; shift is phase_sel + 1 cells |
| pd_short | input | 1 | Phase detector: 1 = chain too short, 0 = chain too long |
| delay_code | output | 6 | Delay setting for every cell of the chain |
| shift_taps | output | 3 | Number of calibrated cells for the strobe shift |
| locked | output | 1 | Settling wait complete since last reset or mode change |

## Verification
`delay_code` and the lock counter are registered, so each stimulus applied at a falling edge shows up on the outputs just after the next rising edge. The exceptions are:

- A reset release needs two more edges to pass the synchroniser.
- A reset assertion clears `locked` without waiting for an edge.
- `shift_taps` follows `phase_sel` combinationally.

The driver models this pipeline from the requirements. For every cycle it queues the outputs expected after the coming edge. The monitor compares one queued item per cycle, one time unit after each rising edge. This also pins the lock edge to exactly the 258th cycle after release.

// File: rtl/dll_delay_ctrl.sv
module dll_delay_ctrl #(
  parameter int CODE_W = 6,
  parameter int SETTLE = 256
) (
  input  logic              clk,
  input  logic              fabric_rst,
  input  logic              pin_rst,
  input  logic [1:0]        freq_mode,
  input  logic [1:0]        phase_sel,
  input  logic              pd_short,
  output logic [CODE_W-1:0] delay_code,
  output logic [2:0]        shift_taps,
  output logic              locked
);

  localparam int CNT_W = $clog2(SETTLE + 1);
  localparam logic [CNT_W-1:0]  SETTLE_C = CNT_W'(SETTLE);
  localparam logic [CODE_W-1:0] MAX_WIDE = '1;
  localparam logic [CODE_W-1:0] MAX_NARROW = MAX_WIDE >> 1;
  localparam logic [CODE_W-1:0] MID_WIDE = {1'b1, {(CODE_W-1){1'b0}}};
  localparam logic [CODE_W-1:0] MID_NARROW = MID_WIDE >> 1;

  logic             rst_any;
  logic [1:0]       rsync;
  logic             rst_int;
  logic [1:0]       mode_q;
  logic             mode_chg;
  logic             clear;
  logic [CNT_W-1:0] settle_cnt;
  logic [CODE_W-1:0] code_max;
  logic [CODE_W-1:0] code_mid;

  assign rst_any = fabric_rst | pin_rst;

  always_ff @(posedge clk or posedge rst_any) begin
    if (rst_any) rsync <= 2'b11;
    else         rsync <= {rsync[0], 1'b0};
  end

  assign rst_int  = rsync[1];
  assign mode_chg = (freq_mode != mode_q);
  assign clear    = rst_int | mode_chg;
  assign code_max = (mode_q == 2'd0) ? MAX_WIDE : MAX_NARROW;
  assign code_mid = (freq_mode == 2'd0) ? MID_WIDE : MID_NARROW;

  always_ff @(posedge clk) begin
    if (clear) begin
      mode_q     <= freq_mode;
      delay_code <= code_mid;
      settle_cnt <= '0;
    end else begin
      if (pd_short && delay_code < code_max)
        delay_code <= delay_code + 1'b1;
      else if (!pd_short && delay_code != '0)
        delay_code <= delay_code - 1'b1;
      if (settle_cnt != SETTLE_C)
        settle_cnt <= settle_cnt + 1'b1;
    end
  end

  assign shift_taps = {1'b0, phase_sel} + 3'd1;
  assign locked     = (settle_cnt == SETTLE_C) & ~clear;

  // R3
  step_size_chk: assert property (@(posedge clk) disable iff (rst_int)
    !clear |=> (delay_code == $past(delay_code)) ||
               (delay_code == $past(delay_code) + 1'b1) ||
               (delay_code == $past(delay_code) - 1'b1));

  // R5
  narrow_width_chk: assert property (@(posedge clk) disable iff (rst_int)
    (mode_q != 2'd0) |-> !delay_code[CODE_W-1]);

  // R6
  floor_hold_chk: assert property (@(posedge clk) disable iff (rst_int)
    (!clear && delay_code == '0 && !pd_short) |=> delay_code == '0);

  // R7
  lock_hold_chk: assert property (@(posedge clk) disable iff (rst_int)
    locked |=> (locked || mode_chg));

  // R8
  taps_range_chk: assert property (@(posedge clk) disable iff (rst_int)
    (shift_taps >= 3'd1) && (shift_taps <= 3'd4));

  // R10
  mode_restart_chk: assert property (@(posedge clk) disable iff (rst_int)
    (mode_chg && !rst_int) |=>
      (!locked || mode_chg) &&
      (delay_code == ((mode_q == 2'd0) ? MID_WIDE : MID_NARROW)));

endmodule

// File: tb/dll_delay_ctrl_tb.sv
module dll_delay_ctrl_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       fab = 1'b1;
  logic       pin = 1'b0;
  logic [1:0] mode = 2'd0;
  logic [1:0] psel = 2'd0;
  logic       pd_sh = 1'b0;
  logic [5:0] code;
  logic [2:0] taps;
  logic       lk;

  always #(CLK_PERIOD/2) clk = ~clk;

  dll_delay_ctrl u_dut (
    .clk(clk), .fabric_rst(fab), .pin_rst(pin), .freq_mode(mode),
    .phase_sel(psel), .pd_short(pd_sh), .delay_code(code),
    .shift_taps(taps), .locked(lk)
  );

  typedef struct {
    int    code;
    int    taps;
    bit    lk;
    string tag;
  } item_t;

  item_t sb[$];
  int compared = 0;
  int mismatched = 0;
  int m_code = 32;
  int m_cnt = 0;
  bit m_s1 = 1'b1;
  bit m_s0 = 1'b1;
  logic [1:0] m_mode = 2'd0;
  int target = 32;
  string cur_req = "R1";

  task automatic step(bit f, bit p, logic [1:0] md, logic [1:0] ps);
    bit raw;
    bit rst_pre;
    int mx;
    item_t it;
    @(negedge clk);
    pd_sh = (m_code < target);
    fab = f; pin = p; mode = md; psel = ps;
    raw = f | p;
    rst_pre = raw | m_s1;
    if (rst_pre || md != m_mode) begin
      m_mode = md;
      m_code = (md == 2'd0) ? 32 : 16;
      m_cnt = 0;
    end else begin
      mx = (m_mode == 2'd0) ? 63 : 31;
      if (pd_sh && m_code < mx) m_code++;
      else if (!pd_sh && m_code > 0) m_code--;
      if (m_cnt < 256) m_cnt++;
    end
    if (raw) begin m_s1 = 1'b1; m_s0 = 1'b1; end
    else begin m_s1 = m_s0; m_s0 = 1'b0; end
    it.code = m_code;
    it.taps = int'(ps) + 1;
    it.lk = (m_cnt == 256) && !m_s1 && !raw;
    it.tag = cur_req;
    sb.push_back(it);
  endtask

  always @(posedge clk) begin
    item_t e;
    #1;
    if (sb.size() > 0) begin
      e = sb.pop_front();
      compared++;
      if (int'(code) != e.code) begin
        mismatched++;
        $display("FAIL %s delay_code actual=%0d expected=%0d", e.tag, code, e.code);
      end
      compared++;
      if (int'(taps) != e.taps) begin
        mismatched++;
        $display("FAIL %s (R8) shift_taps actual=%0d expected=%0d", e.tag, taps, e.taps);
      end
      compared++;
      if (lk !== e.lk) begin
        mismatched++;
        $display("FAIL %s (R7) locked actual=%0b expected=%0b", e.tag, lk, e.lk);
      end
    end
  end

  initial begin
    cur_req = "R1"; repeat (3) step(1, 0, 2'd0, 2'd0);
    cur_req = "R2"; target = 40; repeat (4) step(0, 0, 2'd0, 2'd0);
    cur_req = "R3"; repeat (20) step(0, 0, 2'd0, 2'd1);
    cur_req = "R7"; repeat (240) step(0, 0, 2'd0, 2'd2);
    cur_req = "R4"; target = 80; repeat (40) step(0, 0, 2'd0, 2'd3);
    cur_req = "R8"; for (int i = 0; i < 4; i++) step(0, 0, 2'd0, 2'(i));
    cur_req = "R6"; target = 0; repeat (70) step(0, 0, 2'd0, 2'd0);
    cur_req = "R9"; target = 20; repeat (2) step(0, 1, 2'd0, 2'd1);
    repeat (270) step(0, 0, 2'd0, 2'd1);
    cur_req = "R10"; target = 40; repeat (3) step(0, 0, 2'd1, 2'd0);
    cur_req = "R5"; repeat (30) step(0, 0, 2'd1, 2'd3);
    cur_req = "R10"; repeat (5) step(0, 0, 2'd3, 2'd2);
    cur_req = "R5"; target = 25; repeat (270) step(0, 0, 2'd2, 2'd1);
    cur_req = "R2"; repeat (2) step(1, 0, 2'd2, 2'd0);
    repeat (10) step(0, 0, 2'd2, 2'd1);
    repeat (2) @(posedge clk);
    #2;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    compared++;
    mismatched++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule